// File: doc/BRIEF.md
# Cartridge-to-RAM DMA Controller

This block is a register-programmed copy engine that moves whole 32-bit words between a main RAM port and a cartridge (ROM) port, in either direction. Software first loads a RAM-side byte address and a cartridge-side byte address over a small 32-bit register bus. It then writes a length value into one of two start registers. The register that is written picks the direction, and that write alone launches the copy.

The length value is the byte count minus one. Both stored addresses are cut down to a 29-bit physical space. An attempt to start with a misaligned address or length is refused and raises an error flag. While a copy runs, a status bit reports busy and all register writes are dropped. Each word costs one source read followed, in the next cycle, by one destination write, and both addresses advance by four. After the last write the engine goes idle and pulses a completion interrupt for one cycle. Both memory ports return read data exactly one cycle after a read request.

Top module: `dmac_top`

## Requirements
- R1: Register map on `reg_addr`: 0x00 RAM byte address, 0x04 cartridge byte address, 0x10 status (bit 0 busy, bit 1 error, other bits zero). Reading 0x00 or 0x04 returns the stored address. All registers reset to zero.
- R2: A write to 0x00 or 0x04 keeps only the low 29 bits. For example, writing 0xB03B62F0 reads back as 0x103B62F0.
- R3: A write to 0x08 starts a copy from RAM to cartridge. A write to 0x0C starts a copy from cartridge to RAM.
- R4: A start value L moves (L+1)/4 words. Word k is read from the source address plus 4k and written to the destination address plus 4k, so the destination ends up holding the source words in order.
- R5: A start is refused when bits [1:0] of either stored address are not 00, or when bits [1:0] of L are not 11. A refused start issues no memory request, leaves both addresses unchanged, keeps busy at 0 and sets the error bit. The next accepted start clears the error bit.
- R6: Busy is 1 from the cycle after an accepted start write for exactly 2 cycles per word. While busy is 1, writes to every register are ignored, including the address registers and both start registers.
- R7: Each word gives one read request on the source port, then, in the next cycle, one write request on the destination port carrying the read data. No request appears while the engine is idle.
- R8: `irq_done` is high for exactly one cycle per accepted copy, in the cycle after the last write, and busy is 0 in that cycle. Afterwards the address registers read start address plus 4 times the word count, within 29 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| ram_req | output | 1 | RAM request |
| ram_we | output | 1 | RAM request is a write |
| ram_addr | output | 29 | RAM byte address |
| ram_wdata | output | 32 | RAM write data |
| ram_rdata | input | 32 | RAM read data, one cycle after a read request |
| cart_req | output | 1 | Cartridge request |
| cart_we | output | 1 | Cartridge request is a write |
| cart_addr | output | 29 | Cartridge byte address |
| cart_wdata | output | 32 | Cartridge write data |
| cart_rdata | input | 32 | Cartridge read data, one cycle after a read request |
| irq_done | output | 1 | One-cycle completion pulse |

## Verification
A wrong remaining-word count shows up as a busy window that is not exactly twice the word count long, and as a request total that differs from it. Both are visible on the status bit and the ports as soon as the copy ends. A wrong address step or a write that slipped through while busy corrupts the destination contents and the address read back after completion. A faulty alignment check shows as requests, or a missing error bit, in the cycle after the start write. Random lengths and addresses with random upper bits exercise the masking and the word counting, and directed cases cover the refused starts, writes made while busy, and the largest length.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } dma_state_e;

    typedef enum logic {
        DIR_TO_CART = 1'b0,
        DIR_TO_RAM  = 1'b1
    } dma_dir_e;

    localparam int unsigned REG_AW = 5;

    localparam logic [REG_AW-1:0] OFS_RAM_ADDR   = 5'h00;
    localparam logic [REG_AW-1:0] OFS_CART_ADDR  = 5'h04;
    localparam logic [REG_AW-1:0] OFS_GO_TO_CART = 5'h08;
    localparam logic [REG_AW-1:0] OFS_GO_TO_RAM  = 5'h0C;
    localparam logic [REG_AW-1:0] OFS_STATUS     = 5'h10;

endpackage

// File: rtl/dmac_cmd_decode.sv
module dmac_cmd_decode
    import dmac_pkg::*;
#(
    parameter int unsigned ADDR_W = 29,
    parameter int unsigned LEN_W  = 24,
    parameter int unsigned DATA_W = 32
) (
    input  logic                        reg_we,
    input  logic [REG_AW-1:0]           reg_addr,
    input  logic [31:0]                 reg_wdata,
    input  logic                        busy,
    input  logic [ADDR_W-1:0]           ram_addr_cur,
    input  logic [ADDR_W-1:0]           cart_addr_cur,
    output logic                        wr_ram_addr,
    output logic                        wr_cart_addr,
    output logic [ADDR_W-1:0]           new_addr,
    output logic                        start_ok,
    output logic                        start_bad,
    output dma_dir_e                    start_dir,
    output logic [LEN_W-$clog2(DATA_W/8)-1:0] start_words_m1
);
    localparam int unsigned AL_W = $clog2(DATA_W / 8);

    logic accept;
    logic len_hit;
    logic aligned;
    logic unused_wdata_hi;

    always_comb begin
        accept       = reg_we && !busy;
        wr_ram_addr  = accept && (reg_addr == OFS_RAM_ADDR);
        wr_cart_addr = accept && (reg_addr == OFS_CART_ADDR);
        len_hit      = accept && ((reg_addr == OFS_GO_TO_CART) || (reg_addr == OFS_GO_TO_RAM));
        aligned      = (ram_addr_cur[AL_W-1:0] == '0) &&
                       (cart_addr_cur[AL_W-1:0] == '0) &&
                       (&reg_wdata[AL_W-1:0]);
        start_ok       = len_hit && aligned;
        start_bad      = len_hit && !aligned;
        start_dir      = (reg_addr == OFS_GO_TO_RAM) ? DIR_TO_RAM : DIR_TO_CART;
        new_addr       = reg_wdata[ADDR_W-1:0];
        start_words_m1 = reg_wdata[LEN_W-1:AL_W];
    end

    assign unused_wdata_hi = ^reg_wdata[31:ADDR_W] ^ ^reg_wdata[31:LEN_W];

endmodule

// File: rtl/dmac_engine.sv
module dmac_engine
    import dmac_pkg::*;
#(
    parameter int unsigned ADDR_W = 29,
    parameter int unsigned LEN_W  = 24,
    parameter int unsigned DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_ram_addr,
    input  logic                  wr_cart_addr,
    input  logic [ADDR_W-1:0]     new_addr,
    input  logic                  start_ok,
    input  logic                  start_bad,
    input  dma_dir_e              start_dir,
    input  logic [LEN_W-$clog2(DATA_W/8)-1:0] start_words_m1,
    output logic                  busy,
    output logic                  err,
    output logic [ADDR_W-1:0]     ram_addr_cur,
    output logic [ADDR_W-1:0]     cart_addr_cur,
    output logic                  ram_req,
    output logic                  ram_we,
    output logic [DATA_W-1:0]     ram_wdata,
    input  logic [DATA_W-1:0]     ram_rdata,
    output logic                  cart_req,
    output logic                  cart_we,
    output logic [DATA_W-1:0]     cart_wdata,
    input  logic [DATA_W-1:0]     cart_rdata,
    output logic                  irq_done
);
    localparam int unsigned STEP  = DATA_W / 8;
    localparam int unsigned AL_W  = $clog2(STEP);
    localparam int unsigned CNT_W = LEN_W - AL_W;

    typedef struct packed {
        dma_state_e          state;
        dma_dir_e            dir;
        logic [ADDR_W-1:0]   ram_addr;
        logic [ADDR_W-1:0]   cart_addr;
        logic [CNT_W-1:0]    words_left;
        logic                err;
        logic                irq;
    } eng_t;

    eng_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        unique case (st_q.state)
            ST_IDLE: begin
                if (wr_ram_addr)  st_d.ram_addr  = new_addr;
                if (wr_cart_addr) st_d.cart_addr = new_addr;
                if (start_ok) begin
                    st_d.state      = ST_READ;
                    st_d.dir        = start_dir;
                    st_d.words_left = start_words_m1;
                    st_d.err        = 1'b0;
                end else if (start_bad) begin
                    st_d.err = 1'b1;
                end
            end
            ST_READ: begin
                st_d.state = ST_WRITE;
            end
            ST_WRITE: begin
                st_d.ram_addr  = st_q.ram_addr + ADDR_W'(STEP);
                st_d.cart_addr = st_q.cart_addr + ADDR_W'(STEP);
                if (st_q.words_left == '0) begin
                    st_d.state = ST_IDLE;
                    st_d.irq   = 1'b1;
                end else begin
                    st_d.words_left = st_q.words_left - 1'b1;
                    st_d.state      = ST_READ;
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        ram_req    = 1'b0;
        ram_we     = 1'b0;
        cart_req   = 1'b0;
        cart_we    = 1'b0;
        ram_wdata  = cart_rdata;
        cart_wdata = ram_rdata;
        if (st_q.state == ST_READ) begin
            if (st_q.dir == DIR_TO_RAM) cart_req = 1'b1;
            else                        ram_req  = 1'b1;
        end else if (st_q.state == ST_WRITE) begin
            if (st_q.dir == DIR_TO_RAM) begin
                ram_req = 1'b1;
                ram_we  = 1'b1;
            end else begin
                cart_req = 1'b1;
                cart_we  = 1'b1;
            end
        end
    end

    assign busy          = (st_q.state != ST_IDLE);
    assign err           = st_q.err;
    assign ram_addr_cur  = st_q.ram_addr;
    assign cart_addr_cur = st_q.cart_addr;
    assign irq_done      = st_q.irq;

    // R7: a destination write is always preceded by a source read one cycle earlier
    assert_ram_write_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_req && ram_we) |-> $past(cart_req && !cart_we));
    assert_cart_write_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cart_req && cart_we) |-> $past(ram_req && !ram_we));
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ram_req && !cart_req));
    // R8: completion pulse lasts one cycle and follows a write
    assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |=> !irq_done);
    assert_irq_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> (!busy && $past(ram_we || cart_we)));
    // R5: a refused start leaves the engine idle with the error flag set
    assert_bad_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start_bad |=> (!busy && err));
    // R6: register writes cannot move the addresses in the middle of a word
    assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_READ) |=> ($stable(ram_addr_cur) && $stable(cart_addr_cur)));
    // R4: addresses advance by one word after every write
    assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_WRITE) |=> (ram_addr_cur == $past(ram_addr_cur) + ADDR_W'(STEP)));

endmodule

// File: rtl/dmac_rd_mux.sv
module dmac_rd_mux
    import dmac_pkg::*;
#(
    parameter int unsigned ADDR_W = 29
) (
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [ADDR_W-1:0] ram_addr_cur,
    input  logic [ADDR_W-1:0] cart_addr_cur,
    input  logic              busy,
    input  logic              err,
    output logic [31:0]       reg_rdata
);
    always_comb begin
        unique case (reg_addr)
            OFS_RAM_ADDR:  reg_rdata = {{(32-ADDR_W){1'b0}}, ram_addr_cur};
            OFS_CART_ADDR: reg_rdata = {{(32-ADDR_W){1'b0}}, cart_addr_cur};
            OFS_STATUS:    reg_rdata = {30'd0, err, busy};
            default:       reg_rdata = 32'd0;
        endcase
    end
endmodule

// File: rtl/dmac_top.sv
module dmac_top
    import dmac_pkg::*;
#(
    parameter int unsigned ADDR_W = 29,
    parameter int unsigned LEN_W  = 24,
    parameter int unsigned DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic                ram_req,
    output logic                ram_we,
    output logic [ADDR_W-1:0]   ram_addr,
    output logic [DATA_W-1:0]   ram_wdata,
    input  logic [DATA_W-1:0]   ram_rdata,
    output logic                cart_req,
    output logic                cart_we,
    output logic [ADDR_W-1:0]   cart_addr,
    output logic [DATA_W-1:0]   cart_wdata,
    input  logic [DATA_W-1:0]   cart_rdata,
    output logic                irq_done
);
    localparam int unsigned CNT_W = LEN_W - $clog2(DATA_W / 8);

    logic              busy;
    logic              err;
    logic              wr_ram_addr;
    logic              wr_cart_addr;
    logic [ADDR_W-1:0] new_addr;
    logic              start_ok;
    logic              start_bad;
    dma_dir_e          start_dir;
    logic [CNT_W-1:0]  start_words_m1;
    logic [ADDR_W-1:0] ram_addr_cur;
    logic [ADDR_W-1:0] cart_addr_cur;

    dmac_cmd_decode #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_decode (
        .reg_we         (reg_we),
        .reg_addr       (reg_addr),
        .reg_wdata      (reg_wdata),
        .busy           (busy),
        .ram_addr_cur   (ram_addr_cur),
        .cart_addr_cur  (cart_addr_cur),
        .wr_ram_addr    (wr_ram_addr),
        .wr_cart_addr   (wr_cart_addr),
        .new_addr       (new_addr),
        .start_ok       (start_ok),
        .start_bad      (start_bad),
        .start_dir      (start_dir),
        .start_words_m1 (start_words_m1)
    );

    dmac_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_engine (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_ram_addr    (wr_ram_addr),
        .wr_cart_addr   (wr_cart_addr),
        .new_addr       (new_addr),
        .start_ok       (start_ok),
        .start_bad      (start_bad),
        .start_dir      (start_dir),
        .start_words_m1 (start_words_m1),
        .busy           (busy),
        .err            (err),
        .ram_addr_cur   (ram_addr_cur),
        .cart_addr_cur  (cart_addr_cur),
        .ram_req        (ram_req),
        .ram_we         (ram_we),
        .ram_wdata      (ram_wdata),
        .ram_rdata      (ram_rdata),
        .cart_req       (cart_req),
        .cart_we        (cart_we),
        .cart_wdata     (cart_wdata),
        .cart_rdata     (cart_rdata),
        .irq_done       (irq_done)
    );

    dmac_rd_mux #(.ADDR_W(ADDR_W)) u_rd_mux (
        .reg_addr      (reg_addr),
        .ram_addr_cur  (ram_addr_cur),
        .cart_addr_cur (cart_addr_cur),
        .busy          (busy),
        .err           (err),
        .reg_rdata     (reg_rdata)
    );

    assign ram_addr  = ram_addr_cur;
    assign cart_addr = cart_addr_cur;

endmodule

// File: tb/dmac_top_tb.sv
module dmac_top_tb;
    import dmac_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] MASK = 32'h1FFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = OFS_STATUS;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ram_req, ram_we, cart_req, cart_we, irq_done;
    logic [28:0] ram_addr, cart_addr;
    logic [31:0] ram_wdata, cart_wdata;
    logic [31:0] ram_rdata = '0;
    logic [31:0] cart_rdata = '0;

    logic [31:0] ram_mem  [256];
    logic [31:0] cart_mem [256];
    logic [31:0] exp_ram  [256];
    logic [31:0] exp_cart [256];

    int unsigned checks = 0;
    int unsigned fails  = 0;
    int unsigned rd_cnt = 0;
    int unsigned wr_cnt = 0;
    int unsigned irq_cnt = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmac_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ram_req(ram_req), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .cart_req(cart_req), .cart_we(cart_we), .cart_addr(cart_addr),
        .cart_wdata(cart_wdata), .cart_rdata(cart_rdata),
        .irq_done(irq_done)
    );

    always @(posedge clk) begin
        if (ram_req) begin
            if (ram_we) ram_mem[ram_addr[9:2]] <= ram_wdata;
            else        ram_rdata <= ram_mem[ram_addr[9:2]];
        end
        if (cart_req) begin
            if (cart_we) cart_mem[cart_addr[9:2]] <= cart_wdata;
            else         cart_rdata <= cart_mem[cart_addr[9:2]];
        end
    end

    always @(negedge clk) begin
        if ((ram_req && !ram_we) || (cart_req && !cart_we)) rd_cnt++;
        if ((ram_req && ram_we) || (cart_req && cart_we))   wr_cnt++;
        if (irq_done) irq_cnt++;
    end

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_we    = 1'b0;
        reg_addr  = OFS_STATUS;
    endtask

    task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        reg_addr = OFS_STATUS;
    endtask

    function automatic int unsigned mem_diff();
        int unsigned n = 0;
        for (int i = 0; i < 256; i++) begin
            if (ram_mem[i] !== exp_ram[i])   n++;
            if (cart_mem[i] !== exp_cart[i]) n++;
        end
        return n;
    endfunction

    task automatic model_copy(input bit to_ram, input logic [31:0] ra, input logic [31:0] ca,
                              input int unsigned words);
        for (int k = 0; k < int'(words); k++) begin
            int unsigned ri = ((ra >> 2) + k) & 255;
            int unsigned ci = ((ca >> 2) + k) & 255;
            if (to_ram) exp_ram[ri]  = exp_cart[ci];
            else        exp_cart[ci] = exp_ram[ri];
        end
    endtask

    task automatic run_xfer(input bit to_ram, input logic [31:0] ra, input logic [31:0] ca,
                            input logic [31:0] len, input bit disturb);
        int unsigned words = (len[23:0] >> 2) + 1;
        int unsigned n = 0;
        int unsigned r0, w0, i0;
        logic [31:0] rd;
        reg_write(OFS_RAM_ADDR, ra);
        reg_write(OFS_CART_ADDR, ca);
        reg_read(OFS_RAM_ADDR, rd);
        check("R2 ram address masked", rd, ra & MASK);
        reg_read(OFS_CART_ADDR, rd);
        check("R2 cart address masked", rd, ca & MASK);
        model_copy(to_ram, ra, ca, words);
        r0 = rd_cnt; w0 = wr_cnt; i0 = irq_cnt;
        reg_write(to_ram ? OFS_GO_TO_RAM : OFS_GO_TO_CART, len);
        reg_read(OFS_STATUS, rd);
        while (rd[0] && n < 4000) begin
            n++;
            if (disturb && n == 2)      reg_write(OFS_RAM_ADDR, 32'h0FFF_FFF0);
            else if (disturb && n == 3) reg_write(OFS_GO_TO_RAM, 32'h0000_0003);
            else                        @(negedge clk);
            reg_read(OFS_STATUS, rd);
        end
        check("R6 busy cycles = 2 per word", n, 2 * words);
        @(negedge clk);
        @(negedge clk);
        check("R8 one completion pulse", irq_cnt - i0, 1);
        check("R7 source reads per word", rd_cnt - r0, words);
        check("R7 destination writes per word", wr_cnt - w0, words);
        reg_read(OFS_STATUS, rd);
        check("R5 status clear after accepted start", rd, 32'h0);
        reg_read(OFS_RAM_ADDR, rd);
        check("R8 final ram address (R6 write ignored)", rd, (ra + 4 * words) & MASK);
        reg_read(OFS_CART_ADDR, rd);
        check("R8 final cart address", rd, (ca + 4 * words) & MASK);
        check(to_ram ? "R3 R4 cart to ram contents" : "R3 R4 ram to cart contents", mem_diff(), 0);
    endtask

    task automatic bad_start(input logic [31:0] ra, input logic [31:0] ca, input logic [31:0] len);
        int unsigned r0, w0;
        logic [31:0] rd;
        reg_write(OFS_RAM_ADDR, ra);
        reg_write(OFS_CART_ADDR, ca);
        r0 = rd_cnt; w0 = wr_cnt;
        reg_write(OFS_GO_TO_RAM, len);
        reg_read(OFS_STATUS, rd);
        check("R5 refused start: error set, busy clear", rd, 32'h2);
        repeat (4) @(negedge clk);
        check("R5 refused start issues no request", (rd_cnt - r0) + (wr_cnt - w0), 0);
        reg_read(OFS_RAM_ADDR, rd);
        check("R5 refused start keeps ram address", rd, ra & MASK);
        check("R5 refused start leaves memories", mem_diff(), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) begin
            ram_mem[i]  = $urandom;
            cart_mem[i] = $urandom;
            exp_ram[i]  = ram_mem[i];
            exp_cart[i] = cart_mem[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);

        reg_read(OFS_STATUS, rd);
        check("R1 reset status", rd, 32'h0);
        reg_read(OFS_RAM_ADDR, rd);
        check("R1 reset ram address", rd, 32'h0);
        reg_read(OFS_CART_ADDR, rd);
        check("R1 reset cart address", rd, 32'h0);
        check("R8 no completion pulse after reset", irq_cnt, 0);
        check("R7 no requests after reset", rd_cnt + wr_cnt, 0);

        // directed: example address masking and full 0x300-byte copy
        run_xfer(1'b1, 32'h8021_5230, 32'hB03B_62F0, 32'h0000_02FF, 1'b0);
        // single word each way
        run_xfer(1'b0, 32'h0000_0000, 32'h0000_0040, 32'h0000_0003, 1'b0);
        run_xfer(1'b1, 32'h0000_03FC, 32'hFFFF_FFFC, 32'h0000_0003, 1'b0);
        // writes while busy are ignored
        run_xfer(1'b0, 32'h0000_0100, 32'hA000_0200, 32'h0000_001F, 1'b1);
        run_xfer(1'b1, 32'h0000_0080, 32'h1000_0010, 32'h0000_000F, 1'b1);

        // refused starts
        bad_start(32'h0000_0102, 32'h0000_0200, 32'h0000_000F);
        bad_start(32'h0000_0100, 32'h0000_0201, 32'h0000_000F);
        bad_start(32'h0000_0100, 32'h0000_0200, 32'h0000_02FE);
        // an accepted start afterwards clears the error (checked inside)
        run_xfer(1'b1, 32'h0000_0100, 32'h0000_0200, 32'h0000_0007, 1'b0);

        // constrained random transfers
        for (int t = 0; t < 24; t++) begin
            logic [31:0] ra = $urandom & 32'hFFFF_FFFC;
            logic [31:0] ca = $urandom & 32'hFFFF_FFFC;
            logic [31:0] ln = ($urandom_range(0, 63) << 2) | 32'h3;
            run_xfer(1'($urandom_range(0, 1)), ra, ca, ln, 1'($urandom_range(0, 1)));
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule